// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, for one bank of interrupt levels, whether a new interrupt should be raised and which level wins. It reads four inputs: the pending-request vector, the in-service vector and the mask vector, plus a pointer that names the current lowest-priority level. Priority is circular. The level just after the pointer ranks highest, and the ranking wraps from the top level back to level 0. Moving the pointer therefore rotates the whole ranking. The request, in-service and mask vectors live outside this block, and it only evaluates them.

An evaluation runs when the owner pulses a one-cycle service strobe. The result is registered on the next clock edge, as an interrupt flag and the latched winning level. Once the flag is set it stays up until one of two things happens: the owner pulses an acknowledge-clear, or a later evaluation finds no unmasked request at all. Normal nesting is the default: an in-service level shuts out itself and every level ranked below it. A special-mask input replaces that rule. With it, only the in-service levels themselves are skipped.

The block also offers a combinational one-hot vector. It marks the in-service bit that a non-specific end-of-interrupt command should clear, and the owner applies it to its own in-service register.

Top module: `rot_irq_resolver`

## Requirements
- R1: After reset `intOut` is 0 and `levelOut` is 0.
- R2: The highest-priority level is `lowPtr + 1` modulo NUM_LEVELS (pointer 7 makes level 0 highest). Levels rank in increasing order from there, wrapping around, and `levelOut` reports the first eligible candidate in that order.
- R3: A level is a candidate only when its bit in `reqVec` is 1 and its bit in `maskVec` is 0. A masked request never wins.
- R4: With `specialMask` = 0, the eligible window runs from the highest position up to, but not including, the first level whose `inSvcVec` bit is 1. If the highest position is itself in service, the evaluation changes nothing, and that includes not dropping `intOut`.
- R5: With `specialMask` = 1, every candidate whose `inSvcVec` bit is 0 is eligible, whatever its rank. Candidates whose `inSvcVec` bit is 1 are skipped.
- R6: An evaluation made while `intOut` is 1, with no `ackClear` in the same cycle, raises nothing new, and `levelOut` keeps its value.
- R7: An evaluation that is not blocked under R4 and finds no candidate drives `intOut` to 0.
- R8: `ackClear` drives `intOut` to 0 on the next edge. If `svcStrobe` arrives in the same cycle, that evaluation treats `intOut` as already clear and may raise a new interrupt.
- R9: `eoiClearVec` is combinational. It is one-hot at the first set `inSvcVec` bit, scanning circularly from the highest position, and all zeros when no bit is in service.
- R10: `intOut` and `levelOut` change only on the clock edge that follows a cycle with `svcStrobe` or `ackClear` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| svcStrobe | input | 1 | One-cycle request to evaluate the vectors |
| ackClear | input | 1 | One-cycle clear of the interrupt flag |
| reqVec | input | NUM_LEVELS (8) | Pending requests |
| inSvcVec | input | NUM_LEVELS (8) | Levels currently in service |
| maskVec | input | NUM_LEVELS (8) | Request mask, 1 = masked |
| lowPtr | input | LVL_W (3) | Current lowest-priority level |
| specialMask | input | 1 | 1 = skip only in-service levels |
| intOut | output | 1 | Registered interrupt flag |
| levelOut | output | LVL_W (3) | Latched winning level |
| eoiClearVec | output | NUM_LEVELS (8) | In-service bit a non-specific EOI clears |

## Verification
The assertions assume two things about the inputs. First, `svcStrobe` and `ackClear` are single-cycle pulses. Second, the vectors and the pointer are valid in the cycle of a strobe, because the winning-level checks compare against what was presented one edge earlier. The stimulus drives each operation for exactly one cycle on the falling edge and then returns both strobes to 0. Between operations the vectors hold their last value, so every evaluation sees a settled, self-consistent set of inputs.

// File: rtl/rot_irq_pkg.sv
package rot_irq_pkg;

  typedef struct packed {
    logic setInt;
    logic clrInt;
  } ctrlStrobes_t;

endpackage

// File: rtl/rot_irq_scan.sv
module rot_irq_scan #(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] reqVec,
  input  logic [NUM_LEVELS-1:0] inSvcVec,
  input  logic [NUM_LEVELS-1:0] maskVec,
  input  logic [LVL_W-1:0]      lowPtr,
  input  logic                  specialMask,
  output logic                  blocked,
  output logic                  anyCand,
  output logic                  winValid,
  output logic [LVL_W-1:0]      winLevel,
  output logic [NUM_LEVELS-1:0] eoiClearVec
);

  function automatic logic [LVL_W:0] firstSet(input logic [NUM_LEVELS-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LVL_W'(i)};
    end
    return r;
  endfunction

  logic [LVL_W-1:0]      topPos;
  logic [NUM_LEVELS-1:0] candVec;
  logic [NUM_LEVELS-1:0] rotIsr;
  logic [NUM_LEVELS-1:0] rotCand;
  logic [NUM_LEVELS-1:0] allowed;
  logic [LVL_W:0]        isrHit;
  logic [LVL_W:0]        winHit;

  assign topPos  = lowPtr + LVL_W'(1);
  assign candVec = reqVec & ~maskVec;
  assign anyCand = |candVec;

  // Rotate both vectors so index 0 is the highest-priority level.
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_rot
    logic [LVL_W-1:0] srcIdx;
    assign srcIdx     = topPos + LVL_W'(g);
    assign rotIsr[g]  = inSvcVec[srcIdx];
    assign rotCand[g] = candVec[srcIdx];
    assign allowed[g] = specialMask ? ~rotIsr[g]
                                    : (~isrHit[LVL_W] | (LVL_W'(g) < isrHit[LVL_W-1:0]));
  end

  assign isrHit   = firstSet(rotIsr);
  assign winHit   = firstSet(rotCand & allowed);
  assign blocked  = ~specialMask & isrHit[LVL_W] & (isrHit[LVL_W-1:0] == '0);
  assign winValid = winHit[LVL_W];
  assign winLevel = topPos + winHit[LVL_W-1:0];

  always_comb begin
    eoiClearVec = '0;
    if (isrHit[LVL_W]) eoiClearVec[topPos + isrHit[LVL_W-1:0]] = 1'b1;
  end

endmodule

// File: rtl/rot_irq_ctrl.sv
module rot_irq_ctrl
  import rot_irq_pkg::*;
(
  input  logic         svcStrobe,
  input  logic         ackClear,
  input  logic         intOut,
  input  logic         blocked,
  input  logic         anyCand,
  input  logic         winValid,
  output ctrlStrobes_t strobes
);

  logic intBusy;
  logic evalGo;

  assign intBusy = intOut & ~ackClear;
  assign evalGo  = svcStrobe & ~blocked;

  always_comb begin
    strobes.setInt = evalGo & anyCand & ~intBusy & winValid;
    strobes.clrInt = ackClear | (evalGo & ~anyCand & intOut);
  end

endmodule

// File: rtl/rot_irq_outreg.sv
module rot_irq_outreg
  import rot_irq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LVL_W-1:0] winLevel,
  output logic             intOut,
  output logic [LVL_W-1:0] levelOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOut   <= 1'b0;
      levelOut <= '0;
    end else if (strobes.setInt) begin
      intOut   <= 1'b1;
      levelOut <= winLevel;
    end else if (strobes.clrInt) begin
      intOut   <= 1'b0;
    end
  end

endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver
  import rot_irq_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  svcStrobe,
  input  logic                  ackClear,
  input  logic [NUM_LEVELS-1:0] reqVec,
  input  logic [NUM_LEVELS-1:0] inSvcVec,
  input  logic [NUM_LEVELS-1:0] maskVec,
  input  logic [LVL_W-1:0]      lowPtr,
  input  logic                  specialMask,
  output logic                  intOut,
  output logic [LVL_W-1:0]      levelOut,
  output logic [NUM_LEVELS-1:0] eoiClearVec
);

  ctrlStrobes_t     strobes;
  logic             blocked;
  logic             anyCand;
  logic             winValid;
  logic [LVL_W-1:0] winLevel;

  rot_irq_scan #(.NUM_LEVELS(NUM_LEVELS)) i_scan (
    .reqVec(reqVec), .inSvcVec(inSvcVec), .maskVec(maskVec),
    .lowPtr(lowPtr), .specialMask(specialMask),
    .blocked(blocked), .anyCand(anyCand), .winValid(winValid),
    .winLevel(winLevel), .eoiClearVec(eoiClearVec)
  );

  rot_irq_ctrl i_ctrl (
    .svcStrobe(svcStrobe), .ackClear(ackClear), .intOut(intOut),
    .blocked(blocked), .anyCand(anyCand), .winValid(winValid),
    .strobes(strobes)
  );

  rot_irq_outreg #(.LVL_W(LVL_W)) i_outreg (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winLevel(winLevel),
    .intOut(intOut), .levelOut(levelOut)
  );

endmodule

// File: rtl/rot_irq_resolver_chk.sv
module rot_irq_resolver_chk #(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  svcStrobe,
  input logic                  ackClear,
  input logic [NUM_LEVELS-1:0] reqVec,
  input logic [NUM_LEVELS-1:0] inSvcVec,
  input logic [NUM_LEVELS-1:0] maskVec,
  input logic [LVL_W-1:0]      lowPtr,
  input logic                  specialMask,
  input logic                  intOut,
  input logic [LVL_W-1:0]      levelOut,
  input logic [NUM_LEVELS-1:0] eoiClearVec
);

  logic [NUM_LEVELS-1:0] prevCand;
  logic [NUM_LEVELS-1:0] prevIsr;
  logic                  prevSpecial;

  always_ff @(posedge clk) begin
    prevCand    <= reqVec & ~maskVec;
    prevIsr     <= inSvcVec;
    prevSpecial <= specialMask;
  end

  p_int_rise_after_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> $past(svcStrobe));

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!svcStrobe && !ackClear) |=> ($stable(intOut) && $stable(levelOut)));

  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackClear && !svcStrobe) |=> !intOut);

  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && !ackClear) |=> ($stable(levelOut) && intOut == $past(intOut) || !intOut));

  p_winner_unmasked_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> prevCand[levelOut]);

  p_special_skip_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(intOut) && prevSpecial) |-> !prevIsr[levelOut]);

  p_eoi_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(eoiClearVec) && ((eoiClearVec & ~inSvcVec) == '0));

  p_eoi_present_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inSvcVec != '0) |-> ($countones(eoiClearVec) == 1));

endmodule

bind rot_irq_resolver rot_irq_resolver_chk #(.NUM_LEVELS(NUM_LEVELS)) i_chk (.*);

// File: tb/test_rot_irq_resolver.sv
module test_rot_irq_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic       expInt;
    logic [2:0] expLvl;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       svcStrobe = 1'b0;
  logic       ackClear = 1'b0;
  logic [7:0] reqVec = '0;
  logic [7:0] inSvcVec = '0;
  logic [7:0] maskVec = '0;
  logic [2:0] lowPtr = 3'd7;
  logic       specialMask = 1'b0;
  logic       intOut;
  logic [2:0] levelOut;
  logic [7:0] eoiClearVec;

  int   nChecks = 0;
  int   nFails = 0;
  logic mInt = 1'b0;
  logic [2:0] mLvl = '0;
  item_t scoreQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rot_irq_resolver i_rot_irq_resolver (
    .clk(clk), .rstN(rstN), .svcStrobe(svcStrobe), .ackClear(ackClear),
    .reqVec(reqVec), .inSvcVec(inSvcVec), .maskVec(maskVec),
    .lowPtr(lowPtr), .specialMask(specialMask),
    .intOut(intOut), .levelOut(levelOut), .eoiClearVec(eoiClearVec)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic strobe, input logic ack);
    logic [2:0] hp;
    logic [7:0] cand;
    int limit;
    logic blk;
    logic busy;
    hp = lowPtr + 3'd1;
    cand = reqVec & ~maskVec;
    limit = 8;
    blk = 1'b0;
    busy = mInt && !ack;
    if (!specialMask && inSvcVec != 0) begin
      for (int k = 0; k < 8; k++) begin
        if (inSvcVec[3'(hp + 3'(k))]) begin
          limit = k;
          break;
        end
      end
      if (limit == 0) blk = 1'b1;
    end
    if (ack) mInt = 1'b0;
    if (strobe && !blk) begin
      if (cand != 0) begin
        if (!busy) begin
          for (int k = 0; k < limit; k++) begin
            logic [2:0] p;
            p = hp + 3'(k);
            if (specialMask && inSvcVec[p]) continue;
            if (cand[p]) begin
              mInt = 1'b1;
              mLvl = p;
              break;
            end
          end
        end
      end else begin
        mInt = 1'b0;
      end
    end
  endtask

  task automatic op(input logic [7:0] rq, input logic [7:0] is, input logic [7:0] mk,
                    input logic [2:0] lp, input logic sm, input logic strobe,
                    input logic ack, input string tag);
    item_t it;
    @(negedge clk);
    reqVec = rq; inSvcVec = is; maskVec = mk; lowPtr = lp; specialMask = sm;
    svcStrobe = strobe; ackClear = ack;
    model(strobe, ack);
    it.expInt = mInt; it.expLvl = mLvl; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    svcStrobe = 1'b0; ackClear = 1'b0;
  endtask

  task automatic eoiCheck(input logic [7:0] is, input logic [2:0] lp,
                          input logic [7:0] exp);
    @(negedge clk);
    inSvcVec = is; lowPtr = lp;
    #1;
    check("R9 eoiClearVec", eoiClearVec, exp);
  endtask

  // Monitor: compares the registered outputs just after each edge.
  always @(posedge clk) begin
    #1;
    if (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      check({it.tag, " intOut"}, {7'd0, intOut}, {7'd0, it.expInt});
      if (it.expInt) check({it.tag, " levelOut"}, {5'd0, levelOut}, {5'd0, it.expLvl});
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset intOut", {7'd0, intOut}, 8'd0);
    check("R1 reset levelOut", {5'd0, levelOut}, 8'd0);
    @(negedge clk);
    rstN = 1'b1;

    op(8'h10, 8'h00, 8'hFF, 3'd7, 1'b0, 1'b1, 1'b0, "R3 all masked");
    op(8'h14, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R2 lowest first from 0");
    op(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R6 no re-signal");
    op(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, "R10 idle hold");
    op(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, "R8 ack clears");
    op(8'h81, 8'h00, 8'h00, 3'd3, 1'b0, 1'b1, 1'b0, "R2 rotated wrap");
    op(8'h81, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, "R8 ack clears");
    op(8'h85, 8'h00, 8'h80, 3'd3, 1'b0, 1'b1, 1'b0, "R3 masked skip");
    op(8'h85, 8'h00, 8'h80, 3'd3, 1'b0, 1'b0, 1'b1, "R8 ack clears");
    op(8'h08, 8'h04, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R4 below in-service");
    op(8'h0A, 8'h04, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R4 above in-service");
    op(8'h00, 8'h01, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R4 top blocked keeps int");
    op(8'h00, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, "R7 no request drops");
    op(8'h03, 8'h01, 8'h00, 3'd7, 1'b1, 1'b1, 1'b0, "R5 special skips isr");
    op(8'h03, 8'h01, 8'h00, 3'd7, 1'b1, 1'b0, 1'b1, "R8 ack clears");
    op(8'h05, 8'h05, 8'h00, 3'd7, 1'b1, 1'b1, 1'b0, "R5 only isr levels");
    op(8'h0D, 8'h05, 8'h00, 3'd7, 1'b1, 1'b1, 1'b0, "R5 below isr allowed");
    op(8'h20, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 1'b1, "R8 ack with strobe");
    op(8'h20, 8'h00, 8'hFF, 3'd7, 1'b0, 1'b1, 1'b0, "R7 masked drops");

    eoiCheck(8'h90, 3'd7, 8'h10);
    eoiCheck(8'h90, 3'd4, 8'h80);
    eoiCheck(8'h00, 3'd2, 8'h00);
    eoiCheck(8'h81, 3'd6, 8'h80);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule